// File: doc/BRIEF.md
# Serial Port Interrupt Controller

This block gathers the interrupt causes of an asynchronous serial port and turns them into one prioritised request toward the CPU. There are three causes: receive error, receive complete and transmit complete. Each cause has a sticky flag that latches on its event and an enable bit. The port has one 2-bit priority level. A request is raised only when a flag and its enable are both 1 and the port priority is strictly above the CPU's current 2-bit mask level. Alongside the request, the block presents the vector address of the cause it has chosen.

The receiver supplies a frame-done pulse and three separate error indications: parity, framing and overrun. The transmitter supplies a done pulse. The block keeps a sticky status bit for each error type, so software can tell which error caused the shared error flag. A plain register port gives access to all of this state:

| Address | Contents |
|---|---|
| 0 | Cause flags: bit0 error, bit1 receive complete, bit2 transmit complete. Write 1 to clear. |
| 1 | Enables, with the same bit order as address 0. |
| 2 | Priority, bits [1:0]. |
| 3 | Error status: bit0 parity, bit1 framing, bit2 overrun. Write 1 to clear. |

The arbiter is a small state machine whose state names the cause being requested:

- `ST_IDLE`: no request.
- `ST_ERR`: receive error requested.
- `ST_RXC`: receive complete requested.
- `ST_TXC`: transmit complete requested.

On every clock the machine moves to the state of the highest eligible cause, in the order error, then receive complete, then transmit complete. It moves to `ST_IDLE` when no cause is eligible. Any state can reach any other state in one step. The request and vector outputs are decoded from this state register.

Top module: `sic_serial_irq`

## Requirements
- R1: After reset, all cause flags, enables, priority and error status bits read 0, `irq_req` is 0 and `irq_vector` is 0.
- R2: A `rx_done` pulse sets the receive-complete flag (address 0, bit1). The flag is readable one clock later.
- R3: A parity or framing error sets both the error flag (address 0, bit0) and the receive-complete flag. An overrun error sets only the error flag.
- R4: A `tx_done` pulse sets the transmit-complete flag (address 0, bit2).
- R5: Each error type sets its own sticky status bit at address 3: bit0 parity, bit1 framing, bit2 overrun.
- R6: Writing 1 to a bit of address 0 or address 3 clears that bit. Writing 0 leaves the bit unchanged. An event arriving in the same cycle as the clearing write wins, and the bit stays 1.
- R7: Flags latch even when their enable bit is 0. A disabled flag never produces a request.
- R8: `irq_req` is 1 only when some flag and its enable are both 1 and the priority is strictly greater than `cpu_mask`. A priority of 0 never produces a request.
- R9: `irq_vector` is 0x000028 for the error cause, 0x00002A for receive complete and 0x00002C for transmit complete. When several causes are eligible, the error cause is chosen first, then receive complete, then transmit complete. The vector is 0 when there is no request.
- R10: `irq_req` and `irq_vector` are registered. They follow a change of flag, enable, priority or mask one clock later, which is two clocks after an event pulse.
- R11: The enables (address 1, bits [2:0]) and the priority (address 2, bits [1:0]) read back as written. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_done | input | 1 | Received frame moved into the receive buffer (pulse) |
| rx_parity_err | input | 1 | Parity error detected (pulse) |
| rx_frame_err | input | 1 | Framing error detected (pulse) |
| rx_overrun_err | input | 1 | Overrun error detected (pulse) |
| tx_done | input | 1 | Transmission finished (pulse) |
| cpu_mask | input | 2 | CPU's current interrupt mask level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vector | output | 24 | Vector address of the chosen cause |

## Verification
Register reads are combinational, so they show state in the same cycle the address is driven. Flags and status bits change on the clock edge that samples an event or a write. The request and vector change one edge after that, because they are computed from the flag, enable and priority values and from the mask driven in the cycle before. The bench drives inputs on the falling edge and updates its model at the rising edge. It compares the request and vector at the next falling edge against values derived from the model state held before that edge. Register reads are compared a moment after the address is driven, against the model as it stands after that update.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int NCAUSE = 3;
    localparam int CI_ERR = 0;
    localparam int CI_RXC = 1;
    localparam int CI_TXC = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ERR  = 2'd1,
        ST_RXC  = 2'd2,
        ST_TXC  = 2'd3
    } arb_state_e;
endpackage

// File: rtl/sic_flags.sv
module sic_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_cause,
    input  logic [N-1:0] clr_cause,
    input  logic [N-1:0] set_stat,
    input  logic [N-1:0] clr_stat,
    output logic [N-1:0] cause_q,
    output logic [N-1:0] stat_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cause_q[i] <= 1'b0;
                stat_q[i]  <= 1'b0;
            end else begin
                cause_q[i] <= (cause_q[i] & ~clr_cause[i]) | set_cause[i];
                stat_q[i]  <= (stat_q[i] & ~clr_stat[i]) | set_stat[i];
            end
        end

        // R6: an event beats a clearing write in the same cycle
        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_cause[i] |=> cause_q[i]);
        // R6: write-one clears when no event arrives
        a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_cause[i] && !set_cause[i]) |=> !cause_q[i]);
        // R7: a latched flag holds until it is cleared
        a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (cause_q[i] && !clr_cause[i]) |=> cause_q[i]);
        // R5: status bits are sticky
        a_r5_stat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[i] && !clr_stat[i]) |=> stat_q[i]);
    end
endmodule

// File: rtl/sic_regs.sv
module sic_regs #(
    parameter int N  = 3,
    parameter int DW = 8,
    parameter int AW = 2,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [N-1:0]  cause_q,
    input  logic [N-1:0]  stat_q,
    output logic [N-1:0]  en_q,
    output logic [PW-1:0] prio_q,
    output logic [N-1:0]  clr_cause,
    output logic [N-1:0]  clr_stat,
    output logic [DW-1:0] rdata
);
    localparam logic [AW-1:0] A_CAUSE = AW'(0);
    localparam logic [AW-1:0] A_EN    = AW'(1);
    localparam logic [AW-1:0] A_PRIO  = AW'(2);
    localparam logic [AW-1:0] A_STAT  = AW'(3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            prio_q <= '0;
        end else if (wr) begin
            if (addr == A_EN)   en_q   <= wdata[N-1:0];
            if (addr == A_PRIO) prio_q <= wdata[PW-1:0];
        end
    end

    always_comb begin
        clr_cause = (wr && addr == A_CAUSE) ? wdata[N-1:0] : '0;
        clr_stat  = (wr && addr == A_STAT)  ? wdata[N-1:0] : '0;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CAUSE: rdata[N-1:0]  = cause_q;
            A_EN:    rdata[N-1:0]  = en_q;
            A_PRIO:  rdata[PW-1:0] = prio_q;
            A_STAT:  rdata[N-1:0]  = stat_q;
            default: rdata = '0;
        endcase
    end

    // R11: enable register only changes on a write to its address
    a_r11_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == A_EN) |=> $stable(en_q));
endmodule

// File: rtl/sic_arb.sv
module sic_arb
    import sic_pkg::*;
#(
    parameter int          N       = 3,
    parameter int          PW      = 2,
    parameter int          VW      = 24,
    parameter logic [VW-1:0] VEC_ERR = 24'h000028,
    parameter logic [VW-1:0] VEC_RXC = 24'h00002A,
    parameter logic [VW-1:0] VEC_TXC = 24'h00002C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pend,
    input  logic [PW-1:0] prio,
    input  logic [PW-1:0] mask,
    output logic          irq_req,
    output logic [VW-1:0] irq_vector
);
    arb_state_e state_q, state_d;
    logic       gate;

    assign gate = (prio > mask);

    always_comb begin
        state_d = ST_IDLE;
        if (gate) begin
            if (pend[CI_ERR])      state_d = ST_ERR;
            else if (pend[CI_RXC]) state_d = ST_RXC;
            else if (pend[CI_TXC]) state_d = ST_TXC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_req    = 1'b1;
        irq_vector = '0;
        unique case (state_q)
            ST_IDLE: irq_req    = 1'b0;
            ST_ERR:  irq_vector = VEC_ERR;
            ST_RXC:  irq_vector = VEC_RXC;
            ST_TXC:  irq_vector = VEC_TXC;
            default: irq_req    = 1'b0;
        endcase
    end

    // R8: a request needs the priority strictly above the mask
    a_r8_prio_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(prio > mask));
    // R8: a request needs an enabled pending cause
    a_r8_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(|pend));
    // R9: error cause is served first
    a_r9_err_first: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gate && pend[CI_ERR]) |-> (irq_vector == VEC_ERR));
    // R9: transmit complete only when nothing else is pending
    a_r9_txc_last: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vector == VEC_TXC) |-> $past(!pend[CI_ERR] && !pend[CI_RXC]));
endmodule

// File: rtl/sic_serial_irq.sv
module sic_serial_irq
    import sic_pkg::*;
#(
    parameter int            DW      = 8,
    parameter int            AW      = 2,
    parameter int            PW      = 2,
    parameter int            VW      = 24,
    parameter logic [VW-1:0] VEC_ERR = 24'h000028,
    parameter logic [VW-1:0] VEC_RXC = 24'h00002A,
    parameter logic [VW-1:0] VEC_TXC = 24'h00002C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_done,
    input  logic          rx_parity_err,
    input  logic          rx_frame_err,
    input  logic          rx_overrun_err,
    input  logic          tx_done,
    input  logic [PW-1:0] cpu_mask,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_req,
    output logic [VW-1:0] irq_vector
);
    localparam int N = NCAUSE;

    logic [N-1:0]  set_cause, set_stat, clr_cause, clr_stat;
    logic [N-1:0]  cause_q, stat_q, en_q;
    logic [PW-1:0] prio_q;
    logic [N-1:0]  pend;

    always_comb begin
        set_cause         = '0;
        set_cause[CI_ERR] = rx_parity_err | rx_frame_err | rx_overrun_err;
        set_cause[CI_RXC] = rx_done | rx_parity_err | rx_frame_err;
        set_cause[CI_TXC] = tx_done;
        set_stat          = {rx_overrun_err, rx_frame_err, rx_parity_err};
    end

    assign pend = cause_q & en_q;

    sic_flags #(.N(N)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_cause(set_cause), .clr_cause(clr_cause),
        .set_stat(set_stat), .clr_stat(clr_stat),
        .cause_q(cause_q), .stat_q(stat_q)
    );

    sic_regs #(.N(N), .DW(DW), .AW(AW), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .cause_q(cause_q), .stat_q(stat_q),
        .en_q(en_q), .prio_q(prio_q),
        .clr_cause(clr_cause), .clr_stat(clr_stat),
        .rdata(reg_rdata)
    );

    sic_arb #(.N(N), .PW(PW), .VW(VW),
              .VEC_ERR(VEC_ERR), .VEC_RXC(VEC_RXC), .VEC_TXC(VEC_TXC)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .pend(pend), .prio(prio_q), .mask(cpu_mask),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    // R3: parity or framing errors also mark receive complete
    a_r3_rxc_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_parity_err || rx_frame_err) |=> cause_q[CI_RXC]);
    // R2: frame-done sets receive complete
    a_r2_rxc_set: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> cause_q[CI_RXC]);
    // R7: a disabled cause alone never yields a request
    a_r7_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> !irq_req);
endmodule

// File: tb/sic_serial_irq_bench.sv
`timescale 1ns/1ps
module sic_serial_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_done = 0, rx_parity_err = 0, rx_frame_err = 0, rx_overrun_err = 0, tx_done = 0;
    logic [1:0]  cpu_mask = 0;
    logic        reg_wr = 0;
    logic [1:0]  reg_addr = 0;
    logic [7:0]  reg_wdata = 0;
    logic [7:0]  reg_rdata;
    logic        irq_req;
    logic [23:0] irq_vector;

    int checks = 0;
    int errors = 0;

    logic [2:0] m_cause = 0, m_en = 0, m_stat = 0;
    logic [1:0] m_prio = 0;

    always #4 clk = ~clk;

    sic_serial_irq u_sic_serial_irq (
        .clk(clk), .rst_n(rst_n),
        .rx_done(rx_done), .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
        .rx_overrun_err(rx_overrun_err), .tx_done(tx_done), .cpu_mask(cpu_mask),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vector(irq_vector)
    );

    function automatic logic [24:0] exp_out(input logic [2:0] c, input logic [2:0] e,
                                            input logic [1:0] p, input logic [1:0] m);
        logic [2:0] pd;
        pd = c & e;
        if (p > m) begin
            if (pd[0]) return {1'b1, 24'h000028};
            if (pd[1]) return {1'b1, 24'h00002A};
            if (pd[2]) return {1'b1, 24'h00002C};
        end
        return 25'd0;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return {5'd0, m_cause};
            2'd1: return {5'd0, m_en};
            2'd2: return {6'd0, m_prio};
            default: return {5'd0, m_stat};
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic rd, pe, fe, oe, td, input logic [1:0] mk,
                       input logic wr, input logic [1:0] ad, input logic [7:0] wd,
                       input string tag);
        logic [24:0] e;
        logic [2:0]  sc, ss, cc, cs;
        rx_done = rd; rx_parity_err = pe; rx_frame_err = fe; rx_overrun_err = oe; tx_done = td;
        cpu_mask = mk; reg_wr = wr; reg_addr = ad; reg_wdata = wd;
        @(posedge clk);
        e  = exp_out(m_cause, m_en, m_prio, mk);
        sc = {td, rd | pe | fe, pe | fe | oe};
        ss = {oe, fe, pe};
        cc = (wr && ad == 2'd0) ? wd[2:0] : 3'd0;
        cs = (wr && ad == 2'd3) ? wd[2:0] : 3'd0;
        m_cause = (m_cause & ~cc) | sc;
        m_stat  = (m_stat & ~cs) | ss;
        if (wr && ad == 2'd1) m_en = wd[2:0];
        if (wr && ad == 2'd2) m_prio = wd[1:0];
        @(negedge clk);
        rx_done = 0; rx_parity_err = 0; rx_frame_err = 0; rx_overrun_err = 0; tx_done = 0;
        reg_wr = 0;
        check({tag, " irq_req"}, {31'd0, irq_req}, {31'd0, e[24]});
        check({tag, " irq_vector"}, {8'd0, irq_vector}, {8'd0, e[23:0]});
    endtask

    task automatic idle(input logic [1:0] mk, input string tag);
        cyc(0, 0, 0, 0, 0, mk, 0, 2'd0, 8'd0, tag);
    endtask

    task automatic rd_chk(input logic [1:0] a, input string tag);
        reg_wr = 0; reg_addr = a;
        #1;
        check({tag, " reg_rdata"}, {24'd0, reg_rdata}, {24'd0, exp_rd(a)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq_req", {31'd0, irq_req}, 32'd0);
        check("R1 irq_vector", {8'd0, irq_vector}, 32'd0);
        for (int a = 0; a < 4; a++) rd_chk(a[1:0], "R1");

        // R2 receive complete flag
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        rd_chk(2'd0, "R2");
        // R6 write-one clear, write-zero no effect
        cyc(0, 0, 0, 0, 0, 0, 1, 2'd0, 8'h00, "R6");
        rd_chk(2'd0, "R6 zero write");
        cyc(0, 0, 0, 0, 0, 0, 1, 2'd0, 8'hFF, "R6");
        rd_chk(2'd0, "R6 clear");
        // R3 parity sets error and receive complete; R5 status
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
        rd_chk(2'd0, "R3 parity");
        rd_chk(2'd3, "R5 parity");
        cyc(0, 0, 0, 0, 0, 0, 1, 2'd0, 8'h07, "R3");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, "R3");
        rd_chk(2'd0, "R3 overrun");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, "R5");
        rd_chk(2'd3, "R5 framing");
        // R4 transmit complete
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R4");
        rd_chk(2'd0, "R4");
        // R7 flags set, enables 0, priority high: no request
        cyc(0, 0, 0, 0, 0, 0, 1, 2'd2, 8'hFF, "R7");
        rd_chk(2'd2, "R11 prio");
        idle(0, "R7");
        idle(0, "R7");
        // R10 enable write: request one clock later; R9 error first
        cyc(0, 0, 0, 0, 0, 0, 1, 2'd1, 8'hFF, "R10");
        rd_chk(2'd1, "R11 en");
        idle(0, "R9 err first");
        // R6 clear status with same-cycle event
        cyc(0, 1, 0, 0, 0, 0, 1, 2'd3, 8'h07, "R6");
        rd_chk(2'd3, "R6 event wins");
        cyc(0, 0, 0, 0, 0, 0, 1, 2'd0, 8'h01, "R9");
        idle(0, "R9 rxc next");
        cyc(0, 0, 0, 0, 0, 0, 1, 2'd0, 8'h02, "R9");
        idle(0, "R9 txc last");
        // R8 priority equal to mask, then priority 0
        idle(2'd3, "R8 equal");
        idle(2'd3, "R8 equal");
        cyc(0, 0, 0, 0, 0, 0, 1, 2'd2, 8'h00, "R8");
        idle(0, "R8 prio zero");
        idle(0, "R8 prio zero");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] a;
            a = 2'($urandom);
            cyc(($urandom % 6) == 0, ($urandom % 12) == 0, ($urandom % 12) == 0,
                ($urandom % 12) == 0, ($urandom % 6) == 0, 2'($urandom),
                ($urandom % 3) == 0, a, 8'($urandom), "R8/R9/R10 random");
            rd_chk(2'($urandom), "R11/R6 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule